// File: doc/BRIEF.md
# Event and gated-time pulse accumulator

This block is an 8-bit accumulator fed by a single external input pin. It has two modes. In event mode it adds one for each pin transition of a selected polarity. In gated mode it adds one for every fixed number of bus clocks during which the pin sits at a selected active level. A single polarity bit covers both uses: it names the counted edge in event mode and the gating level in gated mode.

The pin passes through a synchronizer before any decision uses it. Two sticky flags report the block's events. One records a counted input edge, or in gated mode the trailing edge that closes a gate window. The other records a counter wrap. Each flag has its own interrupt enable, and software clears a flag by writing a one to it. The counter keeps its value through reset, and software may load it at any moment.

Top module: `pulse_accum`

## Requirements
- R1: Reset clears the control bits, both flags, both interrupt enables and the interrupt output. Reset leaves the counter value unchanged.
- R2: Control encoding is ctl[2]=enable, ctl[1]=mode (0 event, 1 gated), ctl[0]=polarity. In event mode with polarity 1, each rising pin edge adds one; with polarity 0, each falling edge adds one. The result shows on cnt_o after the third rising clock edge following the pin change.
- R3: In gated mode the gate is open while the synchronized pin equals the polarity bit. The counter adds one for every 64 consecutive open-gate clocks. Closing the gate discards any partial count.
- R4: Flag encoding is flg[1]=overflow, flg[0]=input edge. In event mode a counted edge sets flg[0]. In gated mode the trailing edge, where the pin leaves the active level, sets flg[0].
- R5: An increment that takes the counter from 0xFF to 0x00 sets flg[1].
- R6: Writing a one to bit k of flg_clr clears flag k and leaves the other flag alone. If a flag is set and cleared in the same cycle, the set wins.
- R7: Interrupt-enable encoding is ie[1]=overflow, ie[0]=input edge. irq_o is high exactly when some flag is set together with its enable bit.
- R8: A counter write takes effect on the next clock in any mode, including while the gate is closed. If an increment falls in the same cycle, the write wins and the increment is dropped.
- R9: With enable at 0, pin activity changes neither the counter nor the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_i | input | 1 | Asynchronous accumulator input |
| ctl_wr | input | 1 | Load the control register |
| ctl_wdata | input | 3 | Control value: enable, mode, polarity |
| cnt_wr | input | 1 | Load the counter |
| cnt_wdata | input | 8 | Counter load value |
| ie_wr | input | 1 | Load the interrupt enables |
| ie_wdata | input | 2 | Enables: overflow, edge |
| flg_clr | input | 2 | Write-one-to-clear strobes for the flags |
| ctl_o | output | 3 | Current control register |
| cnt_o | output | 8 | Current counter value |
| flg_o | output | 2 | Flags: overflow, edge |
| ie_o | output | 2 | Current interrupt enables |
| irq_o | output | 1 | Interrupt request |

## Verification
Event mode is driven with pulse trains that rest low and end with one extra rising transition. The two polarities therefore produce counts that differ by one, which shows which edge is counted. A run with zero full pulses shows that a single edge of the wrong polarity is ignored. Gated mode holds the pin active for a whole number of 64-clock periods plus a remainder, which separates correct division from rounding up. Both polarities are run, and a short window that must not count but must still raise the edge flag is included. A start value near 0xFF is used in both modes so that the wrap raises the overflow flag. Directed cases line up a counter write with an increment on the same clock, toggle the pin while the block is disabled, and pass a reset with a known counter value.

// File: rtl/pacc_pkg.sv
// Package: shared types for the pulse accumulator.
// Assumes the control register is three bits wide and the flag vector two bits wide.
package pacc_pkg;
    typedef struct packed {
        logic en;     // accumulator enabled
        logic gated;  // 1 = gated time mode, 0 = event mode
        logic pol;    // counted edge (event) or active level (gated)
    } pacc_ctl_t;

    localparam int FLG_OVF = 1;
    localparam int FLG_EDG = 0;
    localparam int FLG_W   = 2;
endpackage

// File: rtl/pacc_sync.sv
// Module: pacc_sync
// Synchronizes the asynchronous input pin into the clock domain.
// Provides the settled level and one-cycle rise/fall pulses.
// Assumes STAGES >= 2. Reset drives all stages low.
module pacc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic lvl_o,
    output logic rise_o,
    output logic fall_o
);
    localparam int LAST = STAGES;

    logic [LAST:0] shreg;

    // Purpose: shift the pin through the synchronizer plus one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) shreg <= '0;
        else        shreg <= {shreg[LAST-1:0], pin_i};
    end

    // Purpose: compare the settled sample with the previous one.
    always_comb begin
        lvl_o  = shreg[LAST-1];
        rise_o =  shreg[LAST-1] & ~shreg[LAST];
        fall_o = ~shreg[LAST-1] &  shreg[LAST];
    end
endmodule

// File: rtl/pacc_prescale.sv
// Module: pacc_prescale
// Divides the bus clock while run_i is high and emits a one-cycle tick every DIV clocks.
// Restarts from zero whenever run_i drops, so partial periods are discarded.
// Assumes DIV >= 2.
module pacc_prescale #(
    parameter int DIV = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] phase;

    // Purpose: flag the terminal phase of an open window.
    always_comb tick_o = run_i && (phase == LAST);

    // Purpose: advance the phase while running, otherwise hold at zero.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) phase <= '0;
        else if (tick_o)      phase <= '0;
        else                  phase <= phase + 1'b1;
    end
endmodule

// File: rtl/pacc_core.sv
// Module: pacc_core
// Mode decode, counter and flag logic.
// The counter has no reset. A software load beats an increment.
// A flag set beats a write-one clear in the same cycle.
// Assumes the inputs are already synchronous.
module pacc_core
    import pacc_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  pacc_ctl_t         ctl_i,
    input  logic              lvl_i,
    input  logic              rise_i,
    input  logic              fall_i,
    input  logic              tick_i,
    input  logic              cnt_wr,
    input  logic [CNT_W-1:0]  cnt_wdata,
    input  logic [FLG_W-1:0]  flg_clr,
    output logic              gate_open_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [FLG_W-1:0]  flg_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic              ev_hit;
    logic              trail;
    logic              inc;
    logic [FLG_W-1:0]  set_v;
    logic [CNT_W-1:0]  cnt_q;
    logic [FLG_W-1:0]  flg_q;

    // Purpose: decode the mode and polarity into count and flag events.
    always_comb begin
        ev_hit      = ctl_i.en && !ctl_i.gated && (ctl_i.pol ? rise_i : fall_i);
        gate_open_o = ctl_i.en &&  ctl_i.gated && (lvl_i == ctl_i.pol);
        trail       = ctl_i.en &&  ctl_i.gated && (ctl_i.pol ? fall_i : rise_i);
        inc         = ev_hit || (ctl_i.en && ctl_i.gated && tick_i);
        set_v          = '0;
        set_v[FLG_EDG] = ev_hit || trail;
        set_v[FLG_OVF] = inc && !cnt_wr && (cnt_q == CNT_MAX);
    end

    // Purpose: the counter takes a software load, otherwise the increment; reset does not touch it.
    always_ff @(posedge clk) begin
        if (cnt_wr)   cnt_q <= cnt_wdata;
        else if (inc) cnt_q <= cnt_q + 1'b1;
    end

    // Purpose: sticky flags with write-one clear; a new set has priority.
    always_ff @(posedge clk) begin
        if (!rst_n) flg_q <= '0;
        else        flg_q <= (flg_q & ~flg_clr) | set_v;
    end

    assign cnt_o = cnt_q;
    assign flg_o = flg_q;
endmodule

// File: rtl/pulse_accum.sv
// Module: pulse_accum (top)
// Event or gated-time pulse accumulator with control, enable and flag registers.
// Assumes a synchronous active-low reset. Only pin_i is asynchronous.
module pulse_accum
    import pacc_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int GATE_DIV    = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_i,
    input  logic             ctl_wr,
    input  logic [2:0]       ctl_wdata,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             ie_wr,
    input  logic [1:0]       ie_wdata,
    input  logic [1:0]       flg_clr,
    output logic [2:0]       ctl_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic [1:0]       flg_o,
    output logic [1:0]       ie_o,
    output logic             irq_o
);
    pacc_ctl_t   ctl_q;
    logic [1:0]  ie_q;
    logic        lvl, rise, fall, tick, gate_open;

    // Purpose: control register.
    always_ff @(posedge clk) begin
        if (!rst_n)      ctl_q <= '0;
        else if (ctl_wr) ctl_q <= pacc_ctl_t'(ctl_wdata);
    end

    // Purpose: interrupt enable register.
    always_ff @(posedge clk) begin
        if (!rst_n)     ie_q <= '0;
        else if (ie_wr) ie_q <= ie_wdata;
    end

    pacc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i),
        .lvl_o(lvl), .rise_o(rise), .fall_o(fall)
    );

    pacc_prescale #(.DIV(GATE_DIV)) u_psc (
        .clk(clk), .rst_n(rst_n), .run_i(gate_open), .tick_o(tick)
    );

    pacc_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .ctl_i(ctl_q),
        .lvl_i(lvl), .rise_i(rise), .fall_i(fall), .tick_i(tick),
        .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .flg_clr(flg_clr),
        .gate_open_o(gate_open), .cnt_o(cnt_o), .flg_o(flg_o)
    );

    // Purpose: drive the register views and the combined interrupt.
    always_comb begin
        ctl_o = ctl_q;
        ie_o  = ie_q;
        irq_o = |(flg_o & ie_q);
    end
endmodule

// File: rtl/pulse_accum_checker.sv
// Module: pulse_accum_checker
// Temporal properties on the accumulator ports. Bound into pulse_accum below.
module pulse_accum_checker #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cnt_wr,
    input logic [CNT_W-1:0] cnt_wdata,
    input logic [1:0]       flg_clr,
    input logic [2:0]       ctl_o,
    input logic [CNT_W-1:0] cnt_o,
    input logic [1:0]       flg_o,
    input logic [1:0]       ie_o,
    input logic             irq_o
);
    localparam logic [CNT_W-1:0] CMAX = '1;

    // R1: the cycle after a reset, control, flags and enables read zero
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (ctl_o == 3'b000 && flg_o == 2'b00 && ie_o == 2'b00));

    // R2: without a load, the counter only holds or steps by one
    a_r2_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_wr |=> (cnt_o == $past(cnt_o) || cnt_o == $past(cnt_o) + 1'b1));

    // R5: a wrap from all-ones to zero without a load raises overflow
    a_r5_wrap_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_o == '0 && $past(cnt_o) == CMAX && !$past(cnt_wr) && $past(rst_n)) |-> flg_o[1]);

    // R6: the edge flag stays set until a clear strobe arrives
    a_r6_edge_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flg_o[0] && !flg_clr[0]) |=> flg_o[0]);

    // R7: no request while both enables are off
    a_r7_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (ie_o == 2'b00) |-> !irq_o);

    // R8: a load appears on the next clock
    a_r8_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (cnt_o == $past(cnt_wdata)));

    // R9: a disabled block keeps its count
    a_r9_disabled_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_o[2] && !cnt_wr) |=> $stable(cnt_o));
endmodule

bind pulse_accum pulse_accum_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
    .flg_clr(flg_clr), .ctl_o(ctl_o), .cnt_o(cnt_o), .flg_o(flg_o),
    .ie_o(ie_o), .irq_o(irq_o)
);

// File: tb/pulse_accum_test.sv
`timescale 1ns/1ps
module pulse_accum_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pin_i = 1'b0;
    logic       ctl_wr = 1'b0;
    logic [2:0] ctl_wdata = '0;
    logic       cnt_wr = 1'b0;
    logic [7:0] cnt_wdata = '0;
    logic       ie_wr = 1'b0;
    logic [1:0] ie_wdata = '0;
    logic [1:0] flg_clr = '0;
    logic [2:0] ctl_o;
    logic [7:0] cnt_o;
    logic [1:0] flg_o;
    logic [1:0] ie_o;
    logic       irq_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pulse_accum uut (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
        .ie_wr(ie_wr), .ie_wdata(ie_wdata), .flg_clr(flg_clr),
        .ctl_o(ctl_o), .cnt_o(cnt_o), .flg_o(flg_o), .ie_o(ie_o), .irq_o(irq_o)
    );

    // Vector: {mode, pol, start[8], n[4], exp_cnt[8], exp_flg[2]}
    localparam logic [23:0] VEC [0:6] = '{
        {1'b0, 1'b1, 8'h10, 4'd3, 8'h14, 2'b01},  // R2 rising edges counted
        {1'b0, 1'b0, 8'h10, 4'd3, 8'h13, 2'b01},  // R2 falling edges counted
        {1'b0, 1'b1, 8'hFD, 4'd3, 8'h01, 2'b11},  // R5 event wrap
        {1'b0, 1'b0, 8'hFF, 4'd0, 8'hFF, 2'b00},  // R2 wrong edge ignored
        {1'b1, 1'b1, 8'h05, 4'd2, 8'h07, 2'b01},  // R3 gated high
        {1'b1, 1'b0, 8'hFF, 4'd1, 8'h00, 2'b11},  // R3 R5 gated low wrap
        {1'b1, 1'b1, 8'h00, 4'd0, 8'h00, 2'b01}   // R4 short window
    };

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_ctl(input logic [2:0] v);
        @(negedge clk); ctl_wr = 1'b1; ctl_wdata = v;
        @(negedge clk); ctl_wr = 1'b0;
    endtask

    task automatic wr_cnt(input logic [7:0] v);
        @(negedge clk); cnt_wr = 1'b1; cnt_wdata = v;
        @(negedge clk); cnt_wr = 1'b0;
    endtask

    task automatic wr_ie(input logic [1:0] v);
        @(negedge clk); ie_wr = 1'b1; ie_wdata = v;
        @(negedge clk); ie_wr = 1'b0;
    endtask

    task automatic clr(input logic [1:0] v);
        @(negedge clk); flg_clr = v;
        @(negedge clk); flg_clr = 2'b00;
    endtask

    initial begin
        wait_n(4);
        rst_n = 1'b1;
        wait_n(1);
        chk("R1", "ctl after reset", {5'd0, ctl_o}, 8'h00);
        chk("R1", "flags after reset", {6'd0, flg_o}, 8'h00);
        chk("R1", "ie after reset", {6'd0, ie_o}, 8'h00);
        chk("R1", "irq after reset", {7'd0, irq_o}, 8'h00);

        // Table walk covering both modes and both polarities
        for (int i = 0; i < 7; i++) begin
            logic m, p;
            logic [7:0] st, ec;
            logic [3:0] n;
            logic [1:0] ef;
            {m, p, st, n, ec, ef} = VEC[i];
            wr_ctl({1'b0, m, p});
            pin_i = m ? ~p : 1'b0;
            wait_n(5);
            wr_cnt(st);
            clr(2'b11);
            wr_ctl({1'b1, m, p});
            wait_n(2);
            if (!m) begin
                for (int k = 0; k < int'(n); k++) begin
                    pin_i = 1'b1; wait_n(4);
                    pin_i = 1'b0; wait_n(4);
                end
                pin_i = 1'b1;
                wait_n(6);
            end else begin
                pin_i = p;
                wait_n(64 * int'(n) + 20);
                pin_i = ~p;
                wait_n(6);
            end
            chk(m ? "R3" : "R2", $sformatf("count vec %0d", i), cnt_o, ec);
            chk((ef[1]) ? "R5" : "R4", $sformatf("flags vec %0d", i), {6'd0, flg_o}, {6'd0, ef});
        end

        // R9: pin activity while disabled
        wr_ctl(3'b001);
        for (int k = 0; k < 3; k++) begin
            pin_i = ~pin_i; wait_n(4);
        end
        chk("R9", "count while disabled", cnt_o, 8'h00);
        chk("R9", "flags while disabled", {6'd0, flg_o}, 8'h01);

        // R8: load during gated mode with the gate closed
        wr_ctl(3'b111);
        pin_i = 1'b0;
        wait_n(4);
        wr_cnt(8'h3C);
        wait_n(2);
        chk("R8", "load with gate closed", cnt_o, 8'h3C);

        // R8: load aligned with an event increment
        wr_ctl(3'b001);
        pin_i = 1'b0;
        wait_n(5);
        wr_ctl(3'b101);
        wr_cnt(8'h20);
        clr(2'b11);
        @(negedge clk); pin_i = 1'b1;
        @(negedge clk);
        @(negedge clk); cnt_wr = 1'b1; cnt_wdata = 8'h50;
        @(negedge clk); cnt_wr = 1'b0;
        wait_n(4);
        chk("R8", "load beats increment", cnt_o, 8'h50);
        chk("R4", "edge flag still set", {6'd0, flg_o}, 8'h01);

        // R7: masking
        wr_ie(2'b10);
        chk("R7", "irq with only ovf enabled", {7'd0, irq_o}, 8'h00);
        wr_ie(2'b01);
        chk("R7", "irq with edge enabled", {7'd0, irq_o}, 8'h01);

        // R5/R6: wrap then selective clears
        pin_i = 1'b0; wait_n(4);
        wr_cnt(8'hFF);
        pin_i = 1'b1; wait_n(6);
        chk("R5", "wrap count", cnt_o, 8'h00);
        chk("R5", "wrap flags", {6'd0, flg_o}, 8'h03);
        clr(2'b01);
        chk("R6", "clear edge only", {6'd0, flg_o}, 8'h02);
        wr_ie(2'b10);
        chk("R7", "irq on overflow", {7'd0, irq_o}, 8'h01);
        clr(2'b10);
        chk("R6", "clear overflow", {6'd0, flg_o}, 8'h00);
        chk("R7", "irq after clear", {7'd0, irq_o}, 8'h00);

        // R1: counter survives reset
        wr_cnt(8'hA5);
        @(negedge clk); rst_n = 1'b0;
        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);
        chk("R1", "count kept over reset", cnt_o, 8'hA5);
        chk("R1", "ctl cleared", {5'd0, ctl_o}, 8'h00);
        chk("R1", "ie cleared", {6'd0, ie_o}, 8'h00);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule